// File: doc/BRIEF.md
# Dual Legacy Counter/Timer

This block holds two counter/timers that follow the classic 8-bit controller timer pair. Each timer has an 8-bit low byte and an 8-bit high byte. A timer advances on a selectable time base: the system clock itself, one of three fixed prescaled rates, an external clock divided by eight, or falling edges on its own count pin. A run bit enables counting, and a gate option can also make counting depend on an external level. When a count wraps, a sticky overflow flag is set, and this flag is also the timer's interrupt request. A registered one-cycle overflow pulse is available for use by a serial-port baud generator.

There are four counting modes: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, and a split mode that only timer 0 offers. In split mode timer 0 becomes two independent 8-bit counters, and its high half takes over timer 1's run bit and overflow flag. Software reaches everything through a small synchronous write port and a combinational read port.

Top module: `legacy_ctr_pair`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, every register reads 0x00 and irq and ovf_pulse are 0.
- R2: Address map: 0/1 timer 0 low/high byte, 2/3 timer 1 low/high byte, 4 mode, 5 control, 6 clock setup, 7 reads 0x00. Mode nibbles are bits [3:0] for timer 0 and [7:4] for timer 1, each laid out as {gate[3], pin_src[2], mode[1:0]}. Control has run0 at bit 0, run1 at bit 1, flag0 at bit 4, flag1 at bit 5. Clock setup has prescale select at [1:0], timer 0 system-clock select at bit 2, timer 1 system-clock select at bit 3. Unused bits read 0, and each write takes effect on the next clock edge.
- R3: A timer with pin_src=0 and its system-clock bit set advances every cycle. With that bit clear, it advances on the shared prescaled tick. Select 0 gives 1/12, 1 gives 1/4 and 2 gives 1/48 of the clock, using a free-running modulo-48 phase counter that starts at 0 after reset; a tick occurs when phase mod N equals N-1. Select 3 gives one tick per eight rising edges of ext_clk, seen through two sampling flops.
- R4: With pin_src=1, a timer advances once for each falling edge of its count pin. The edge is found by comparing two consecutive samples of the pin, and the count changes on the edge that follows detection.
- R5: A timer counts only while its run bit is 1. If its gate bit is also 1, gate_pin for that timer must be high as well.
- R6: Mode 0 is a 13-bit counter made of the high byte and bits [4:0] of the low byte. Low-byte bits [7:5] are never changed by counting. The timer wraps when all 13 bits roll to zero.
- R7: Mode 1 is a 16-bit counter that wraps from 0xFFFF to 0x0000.
- R8: In mode 2 the low byte counts. On passing 0xFF it loads the high byte's value, and the high byte is never changed by counting.
- R9: When timer 0 is in mode 3, its low byte is an 8-bit counter under timer 0's run, gate and source, and it sets flag0. Its high byte is an 8-bit counter clocked by timer 0's system-clock or prescaled tick, enabled by run1 alone, and it sets flag1. During this time timer 1 counts from its own source, ignoring run1 and gate; it sets no flag but still produces ovf_pulse[1].
- R10: Timer 1 in mode 3 holds its count.
- R11: A flag is set on the same edge that its counter wraps, and it stays set until software writes 0 to it. If a wrap and a write of 0 to the flag happen in the same cycle, the flag ends up 1. irq mirrors the two flags.
- R12: ovf_pulse[i] is high for the one cycle after each wrap of timer i's main counter.
- R13: A write to a count byte takes priority over counting. Outside split mode, a write to either byte stops that timer from counting in that cycle. In split mode, a write stops only the half that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| ext_clk | input | 1 | External clock, divided by eight when selected |
| cnt_pin | input | 2 | Per-timer count pins, falling edges counted |
| gate_pin | input | 2 | Per-timer gate levels |
| irq | output | 2 | Overflow interrupt requests (flags) |
| ovf_pulse | output | 2 | One-cycle overflow pulses |

## Verification
Two events can collide in one cycle: a counter wrap that sets a flag and a software write to the control register that clears it. Another collision is a count tick arriving on a cycle when software writes a count byte. The bench makes these happen by loading a counter to two steps below wrap and writing the control register on three cycles in a row, and by writing a low byte while a system-clock count is running. A behavioural model, updated every edge, predicts that the flag survives and that the written value replaces the count. A long random phase then produces many more chance collisions, including split-mode half writes.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int BYTE_W  = 8;
    localparam int SHORT_W = 5;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_T0_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_T0_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_T1_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_T1_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CFG   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;
    localparam logic [ADDR_W-1:0] A_CLK   = 3'd6;

    typedef enum logic [1:0] {
        M_SHORT13 = 2'd0,
        M_WIDE16  = 2'd1,
        M_RELOAD8 = 2'd2,
        M_SPLIT   = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        PS_DIV_A = 2'd0,
        PS_DIV_B = 2'd1,
        PS_DIV_C = 2'd2,
        PS_XCLK  = 2'd3
    } pre_sel_e;

    typedef struct packed {
        logic      gate;
        logic      pin_src;
        cnt_mode_e mode;
    } tmr_cfg_t;

    typedef struct packed {
        logic     sys1;
        logic     sys0;
        pre_sel_e sel;
    } clk_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] hi;
        logic              wrap;
    } step_t;

    function automatic step_t step_short(input logic [BYTE_W-1:0] lo,
                                         input logic [BYTE_W-1:0] hi);
        step_t r;
        logic [SHORT_W:0] s;
        logic [BYTE_W:0]  h;
        s = {1'b0, lo[SHORT_W-1:0]} + 1'b1;
        h = {1'b0, hi} + {{BYTE_W{1'b0}}, s[SHORT_W]};
        r.lo   = {lo[BYTE_W-1:SHORT_W], s[SHORT_W-1:0]};
        r.hi   = h[BYTE_W-1:0];
        r.wrap = h[BYTE_W];
        return r;
    endfunction

    function automatic step_t step_wide(input logic [BYTE_W-1:0] lo,
                                        input logic [BYTE_W-1:0] hi);
        step_t r;
        logic [2*BYTE_W:0] w;
        w = {1'b0, hi, lo} + 1'b1;
        r.lo   = w[BYTE_W-1:0];
        r.hi   = w[2*BYTE_W-1:BYTE_W];
        r.wrap = w[2*BYTE_W];
        return r;
    endfunction

    function automatic step_t step_reload(input logic [BYTE_W-1:0] lo,
                                          input logic [BYTE_W-1:0] hi);
        step_t r;
        r.hi   = hi;
        r.wrap = &lo;
        r.lo   = r.wrap ? hi : lo + 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler
    import lct_pkg::*;
#(
    parameter int DIV_A = 12,
    parameter int DIV_B = 4,
    parameter int DIV_C = 48,
    parameter int XDIV  = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  pre_sel_e sel,
    input  logic     ext_clk,
    output logic     tick
);
    localparam int PW = $clog2(DIV_C);
    localparam int XW = $clog2(XDIV);

    logic [PW-1:0] phase_q;
    logic [XW-1:0] xcnt_q;
    logic          xs1_q, xs2_q;
    logic          tick_a, tick_b, tick_c, x_rise, tick_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            xcnt_q  <= '0;
            xs1_q   <= 1'b0;
            xs2_q   <= 1'b0;
        end else begin
            phase_q <= (32'(phase_q) == DIV_C - 1) ? '0 : phase_q + 1'b1;
            xs1_q   <= ext_clk;
            xs2_q   <= xs1_q;
            if (x_rise) xcnt_q <= xcnt_q + 1'b1;
        end
    end

    always_comb begin
        tick_a = (32'(phase_q) % DIV_A) == DIV_A - 1;
        tick_b = (32'(phase_q) % DIV_B) == DIV_B - 1;
        tick_c = 32'(phase_q) == DIV_C - 1;
        x_rise = xs1_q & ~xs2_q;
        tick_x = x_rise && (32'(xcnt_q) == XDIV - 1);
        unique case (sel)
            PS_DIV_A: tick = tick_a;
            PS_DIV_B: tick = tick_b;
            PS_DIV_C: tick = tick_c;
            default:  tick = tick_x;
        endcase
    end

    // R3: the slowest rate lines up with the faster ones
    p_div_nest_r3: assert property (@(posedge clk) disable iff (rst)
        tick_c |-> (tick_a && tick_b));

    // R3: phase wraps to zero after its last value
    p_phase_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        tick_c |=> (phase_q == '0));

endmodule

// File: rtl/lct_fall_detect.sv
module lct_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic fall
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
        end
    end

    assign fall = s2_q & ~s1_q;

    // R4: one edge yields one count request
    p_fall_single_r4: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/lct_counter.sv
module lct_counter
    import lct_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_mode_e         mode,
    input  logic              cnt_main,
    input  logic              cnt_high,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] ld_data,
    output logic [BYTE_W-1:0] lo,
    output logic [BYTE_W-1:0] hi,
    output logic              wrap_main,
    output logic              wrap_high
);
    logic [BYTE_W-1:0] nxt_lo, nxt_hi;
    step_t             st;

    always_comb begin
        nxt_lo    = lo;
        nxt_hi    = hi;
        wrap_main = 1'b0;
        wrap_high = 1'b0;
        st        = '0;
        if (mode == M_SPLIT) begin
            if (SPLIT_OK) begin
                if (cnt_main && !ld_lo) begin
                    nxt_lo    = lo + 1'b1;
                    wrap_main = &lo;
                end
                if (cnt_high && !ld_hi) begin
                    nxt_hi    = hi + 1'b1;
                    wrap_high = &hi;
                end
            end
        end else if (cnt_main && !ld_lo && !ld_hi) begin
            unique case (mode)
                M_SHORT13: st = step_short(lo, hi);
                M_WIDE16:  st = step_wide(lo, hi);
                default:   st = step_reload(lo, hi);
            endcase
            nxt_lo    = st.lo;
            nxt_hi    = st.hi;
            wrap_main = st.wrap;
        end
        if (ld_lo) nxt_lo = ld_data;
        if (ld_hi) nxt_hi = ld_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= nxt_lo;
            hi <= nxt_hi;
        end
    end

    // R7: a 16-bit wrap leaves both bytes at zero
    p_wide_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (wrap_main && mode == M_WIDE16) |=> (lo == '0 && hi == '0));

    // R6: counting never touches the upper low-byte bits
    p_short_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == M_SHORT13 && !ld_lo) |=>
            (lo[BYTE_W-1:SHORT_W] == $past(lo[BYTE_W-1:SHORT_W])));

    // R8: reload copies the high byte and keeps it
    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (wrap_main && mode == M_RELOAD8) |=> (lo == $past(hi) && hi == $past(hi)));

    // R13: a byte write lands regardless of counting
    p_load_wins_r13: assert property (@(posedge clk) disable iff (rst)
        ld_lo |=> (lo == $past(ld_data)));

    generate
        if (!SPLIT_OK) begin : g_halt_chk
            // R10: a timer without split support holds in mode 3
            p_halt_r10: assert property (@(posedge clk) disable iff (rst)
                (mode == M_SPLIT && !ld_lo && !ld_hi) |=> (lo == $past(lo) && hi == $past(hi)));
        end
    endgenerate

endmodule

// File: rtl/legacy_ctr_pair.sv
module legacy_ctr_pair
    import lct_pkg::*;
#(
    parameter int DIV_A = 12,
    parameter int DIV_B = 4,
    parameter int DIV_C = 48,
    parameter int XDIV  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ext_clk,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    output logic [1:0]        irq,
    output logic [1:0]        ovf_pulse
);
    localparam int NT = 2;

    tmr_cfg_t          cfg_q [NT];
    clk_cfg_t          clk_q;
    logic [NT-1:0]     run_q, flag_q, pulse_q;
    logic [BYTE_W-1:0] lo [NT];
    logic [BYTE_W-1:0] hi [NT];
    logic [NT-1:0]     wrap_main, wrap_high, fall, sys_tick, src_tick, gate_ok;
    logic [NT-1:0]     cnt_main, cnt_high, ld_lo, ld_hi, ev;
    logic              pre_tick, split, wr_ctrl;

    lct_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .XDIV(XDIV)) u_pre (
        .clk(clk), .rst(rst), .sel(clk_q.sel), .ext_clk(ext_clk), .tick(pre_tick)
    );

    assign split   = (cfg_q[0].mode == M_SPLIT);
    assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

    generate
        for (genvar i = 0; i < NT; i++) begin : g_tmr
            lct_fall_detect u_edge (
                .clk(clk), .rst(rst), .pin(cnt_pin[i]), .fall(fall[i])
            );

            assign sys_tick[i] = ((i == 0) ? clk_q.sys0 : clk_q.sys1) | pre_tick;
            assign src_tick[i] = cfg_q[i].pin_src ? fall[i] : sys_tick[i];
            assign gate_ok[i]  = ~cfg_q[i].gate | gate_pin[i];
            assign ld_lo[i]    = wr_en && (wr_addr == ADDR_W'(2 * i));
            assign ld_hi[i]    = wr_en && (wr_addr == ADDR_W'(2 * i + 1));

            lct_counter #(.SPLIT_OK(i == 0)) u_cnt (
                .clk(clk), .rst(rst), .mode(cfg_q[i].mode),
                .cnt_main(cnt_main[i]), .cnt_high(cnt_high[i]),
                .ld_lo(ld_lo[i]), .ld_hi(ld_hi[i]), .ld_data(wr_data),
                .lo(lo[i]), .hi(hi[i]),
                .wrap_main(wrap_main[i]), .wrap_high(wrap_high[i])
            );
        end
    endgenerate

    always_comb begin
        cnt_main[0] = run_q[0] & gate_ok[0] & src_tick[0];
        cnt_high[0] = run_q[1] & sys_tick[0];
        cnt_main[1] = split ? src_tick[1] : (run_q[1] & gate_ok[1] & src_tick[1]);
        cnt_high[1] = 1'b0;
        ev[0]       = wrap_main[0];
        ev[1]       = split ? wrap_high[0] : wrap_main[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q[0] <= '0;
            cfg_q[1] <= '0;
            clk_q    <= '0;
            run_q    <= '0;
            flag_q   <= '0;
            pulse_q  <= '0;
        end else begin
            pulse_q <= wrap_main;
            if (wr_ctrl) begin
                run_q  <= wr_data[1:0];
                flag_q <= wr_data[5:4] | ev;
            end else begin
                flag_q <= flag_q | ev;
            end
            if (wr_en && wr_addr == A_CFG) begin
                cfg_q[0] <= tmr_cfg_t'(wr_data[3:0]);
                cfg_q[1] <= tmr_cfg_t'(wr_data[7:4]);
            end
            if (wr_en && wr_addr == A_CLK) clk_q <= clk_cfg_t'(wr_data[3:0]);
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_T0_LO: rd_data = lo[0];
            A_T0_HI: rd_data = hi[0];
            A_T1_LO: rd_data = lo[1];
            A_T1_HI: rd_data = hi[1];
            A_CFG:   rd_data = {cfg_q[1], cfg_q[0]};
            A_CTRL:  rd_data = {2'b00, flag_q, 2'b00, run_q};
            A_CLK:   rd_data = {4'b0000, clk_q};
            default: rd_data = '0;
        endcase
    end

    assign irq       = flag_q;
    assign ovf_pulse = pulse_q;

    // R11: a wrap always leaves its flag raised, even under a clearing write
    p_flag_set_r11: assert property (@(posedge clk) disable iff (rst)
        ev[0] |=> irq[0]);
    p_flag1_set_r11: assert property (@(posedge clk) disable iff (rst)
        ev[1] |=> irq[1]);

    // R11: only a control write drops a flag
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq[0] && !wr_ctrl) |=> irq[0]);

    // R5: timer 0 is frozen while its run bit is clear
    p_idle_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (!run_q[0] && !ld_lo[0] && !ld_hi[0] && !split) |=>
            (lo[0] == $past(lo[0]) && hi[0] == $past(hi[0])));

    // R12: a pulse on timer 0 coincides with its raised flag
    p_pulse_flag_r12: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse[0] |-> irq[0]);

    // R9: in split mode timer 1 never raises flag 1 by itself
    p_split_t1_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (split && !wrap_high[0] && !wr_ctrl && !irq[1]) |=> !irq[1]);

endmodule

// File: tb/tb_legacy_ctr_pair.sv
module tb_legacy_ctr_pair;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_clk = 1'b0;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] irq, ovf_pulse;

    legacy_ctr_pair dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk(ext_clk), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .irq(irq), .ovf_pulse(ovf_pulse)
    );

    always #4 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    int    ncyc  = 0;
    int    xdiv_cnt = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_lo[2], m_hi[2], m_run[2], m_flag[2], m_pulse[2];
    int m_cfg, m_clk, m_p, m_x1, m_x2, m_xc;
    int m_s1[2], m_s2[2];

    function automatic int model_rd(int a);
        case (a)
            0: return m_lo[0];
            1: return m_hi[0];
            2: return m_lo[1];
            3: return m_hi[1];
            4: return m_cfg;
            5: return m_flag[1] * 32 + m_flag[0] * 16 + m_run[1] * 2 + m_run[0];
            6: return m_clk;
            default: return 0;
        endcase
    endfunction

    // one count step of a non-split mode; returns 1 on wrap
    function automatic int mstep(int md, inout int lo, inout int hi);
        int v;
        if (md == 0) begin
            v = hi * 32 + (lo % 32) + 1;
            lo = (lo / 32) * 32 + (v % 32);
            hi = (v / 32) % 256;
            return (v == 8192) ? 1 : 0;
        end else if (md == 1) begin
            v = hi * 256 + lo + 1;
            lo = v % 256;
            hi = (v / 256) % 256;
            return (v == 65536) ? 1 : 0;
        end else begin
            if (lo == 255) begin
                lo = hi;
                return 1;
            end
            lo = lo + 1;
            return 0;
        end
    endfunction

    always @(posedge clk) begin
        int pre, md[2], src[2], sys[2], gok[2], fl[2];
        int w0, w0h, w1, split, a, d;
        bit  wr;
        ncyc++;
        started = 1;
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_lo[i] = 0; m_hi[i] = 0; m_run[i] = 0; m_flag[i] = 0;
                m_pulse[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
            end
            m_cfg = 0; m_clk = 0; m_p = 0; m_x1 = 0; m_x2 = 0; m_xc = 0;
        end else begin
            wr = wr_en; a = wr_addr; d = wr_data;
            case (m_clk % 4)
                0: pre = (m_p % 12 == 11);
                1: pre = (m_p % 4 == 3);
                2: pre = (m_p == 47);
                default: pre = (m_x1 == 1 && m_x2 == 0 && m_xc == 7);
            endcase
            for (int i = 0; i < 2; i++) begin
                int nib;
                nib    = (m_cfg >> (4 * i)) % 16;
                md[i]  = nib % 4;
                sys[i] = ((m_clk >> (2 + i)) % 2 == 1 || pre) ? 1 : 0;
                fl[i]  = (m_s2[i] == 1 && m_s1[i] == 0) ? 1 : 0;
                src[i] = ((nib / 4) % 2 == 1) ? fl[i] : sys[i];
                gok[i] = (nib / 8 == 0 || gate_pin[i]) ? 1 : 0;
            end
            split = (md[0] == 3);
            w0 = 0; w0h = 0; w1 = 0;
            if (split) begin
                if (!(wr && a == 0) && m_run[0] && gok[0] && src[0]) begin
                    w0 = (m_lo[0] == 255);
                    m_lo[0] = (m_lo[0] + 1) % 256;
                end
                if (!(wr && a == 1) && m_run[1] && sys[0]) begin
                    w0h = (m_hi[0] == 255);
                    m_hi[0] = (m_hi[0] + 1) % 256;
                end
            end else if (!(wr && (a == 0 || a == 1)) && m_run[0] && gok[0] && src[0]) begin
                w0 = mstep(md[0], m_lo[0], m_hi[0]);
            end
            if (md[1] != 3 && !(wr && (a == 2 || a == 3)) && src[1] &&
                (split || (m_run[1] && gok[1]))) begin
                w1 = mstep(md[1], m_lo[1], m_hi[1]);
            end
            fl[0] = w0;
            fl[1] = split ? w0h : w1;
            if (wr && a == 5) begin
                m_run[0] = d % 2; m_run[1] = (d / 2) % 2;
                m_flag[0] = ((d / 16) % 2) | fl[0];
                m_flag[1] = ((d / 32) % 2) | fl[1];
            end else begin
                m_flag[0] = m_flag[0] | fl[0];
                m_flag[1] = m_flag[1] | fl[1];
            end
            if (wr && a < 4) begin
                if (a % 2 == 0) m_lo[a / 2] = d; else m_hi[a / 2] = d;
            end
            if (wr && a == 4) m_cfg = d;
            if (wr && a == 6) m_clk = d % 16;
            m_pulse[0] = w0; m_pulse[1] = w1;
            if (m_x1 == 1 && m_x2 == 0) m_xc = (m_xc + 1) % 8;
            m_x2 = m_x1; m_x1 = ext_clk;
            m_p = (m_p + 1) % 48;
            for (int i = 0; i < 2; i++) begin
                m_s2[i] = m_s1[i]; m_s1[i] = cnt_pin[i];
            end
        end
    end

    // compare on every falling edge, before the drivers move
    always @(negedge clk) begin
        if (started && !done) begin
            int exp_rd;
            exp_rd = model_rd(rd_addr);
            n_vec++;
            if (rd_data !== 8'(exp_rd)) begin
                n_bad++;
                $display("FAIL %s rd[%0d] actual %02h expected %02h", cur_req, rd_addr, rd_data, exp_rd);
            end
            n_vec++;
            if (irq !== {1'(m_flag[1]), 1'(m_flag[0])}) begin
                n_bad++;
                $display("FAIL %s irq actual %b expected %b%b", cur_req, irq, m_flag[1][0], m_flag[0][0]);
            end
            n_vec++;
            if (ovf_pulse !== {1'(m_pulse[1]), 1'(m_pulse[0])}) begin
                n_bad++;
                $display("FAIL %s ovf_pulse actual %b expected %b%b", cur_req, ovf_pulse, m_pulse[1][0], m_pulse[0][0]);
            end
        end
    end

    task automatic nxt();
        @(negedge clk);
        #1;
        wr_en = 1'b0;
        rd_addr = rd_addr + 1'b1;
        xdiv_cnt++;
        if (xdiv_cnt % 3 == 0) ext_clk = ~ext_clk;
    endtask

    task automatic wr(input int a, input int d);
        nxt();
        wr_en = 1'b1;
        wr_addr = 3'(a);
        wr_data = 8'(d);
    endtask

    task automatic idle(input int n);
        repeat (n) nxt();
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        while (ncyc < 150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual %0d cycles expected completion", ncyc);
        finish_run();
    end

    initial begin
        cur_req = "R1";
        idle(4);
        rst = 1'b0;
        idle(9);
        // R1: directed check of the outputs right after reset
        n_vec++;
        if (irq !== 2'b00) begin
            n_bad++;
            $display("FAIL R1 irq actual %b expected 00", irq);
        end

        cur_req = "R2";
        wr(0, 8'h12); wr(1, 8'h34); wr(2, 8'h56); wr(3, 8'h78);
        wr(4, 8'hC8); wr(6, 8'hFD); wr(7, 8'hFF);
        idle(10);

        cur_req = "R7";
        wr(6, 8'h0C); wr(4, 8'h11);
        wr(0, 8'hF0); wr(1, 8'hFF); wr(5, 8'h01);
        idle(30);
        wr(5, 8'h00); idle(3);

        cur_req = "R6";
        wr(4, 8'h10); wr(0, 8'hFC); wr(1, 8'hFF); wr(5, 8'h01);
        idle(14);
        wr(5, 8'h00);

        cur_req = "R8";
        wr(4, 8'h12); wr(1, 8'hF0); wr(0, 8'hFD); wr(5, 8'h01);
        idle(40);
        wr(5, 8'h00);

        cur_req = "R3";
        for (int s = 0; s < 4; s++) begin
            wr(6, s); wr(4, 8'h11); wr(0, 8'hF8); wr(1, 8'hFF);
            wr(5, 8'h01);
            idle(260);
            wr(5, 8'h00);
        end

        cur_req = "R4";
        wr(6, 8'h0C); wr(4, 8'h55); wr(0, 8'hFC); wr(1, 8'hFF);
        wr(2, 8'hFE); wr(3, 8'hFF); wr(5, 8'h03);
        for (int k = 0; k < 24; k++) begin
            nxt();
            cnt_pin = cnt_pin ^ ((k % 3 == 0) ? 2'b11 : 2'b01);
            idle(k % 4);
        end
        wr(5, 8'h00);

        cur_req = "R5";
        wr(4, 8'h99); wr(0, 8'hF0); wr(1, 8'hFF); wr(5, 8'h03);
        for (int k = 0; k < 20; k++) begin
            nxt();
            gate_pin = 2'(k % 4);
            idle(2);
        end
        wr(5, 8'h02); idle(6);
        wr(5, 8'h00);

        cur_req = "R9";
        gate_pin = 2'b00;
        wr(4, 8'h13); wr(0, 8'hF8); wr(1, 8'hF0); wr(2, 8'hF0); wr(3, 8'hFF);
        wr(5, 8'h01); idle(40);
        wr(5, 8'h03); idle(40);
        wr(1, 8'hFE); idle(6);
        wr(5, 8'h00);

        cur_req = "R10";
        wr(4, 8'h30); wr(5, 8'h03); idle(20);
        wr(5, 8'h00);

        cur_req = "R11";
        wr(4, 8'h11); wr(0, 8'hFE); wr(1, 8'hFF);
        wr(5, 8'h01); wr(5, 8'h01); wr(5, 8'h01);
        idle(4);

        cur_req = "R13";
        wr(0, 8'h10); wr(0, 8'h20); idle(4);
        wr(4, 8'h13); wr(5, 8'h03); wr(0, 8'hFF); wr(1, 8'hFF); idle(4);
        wr(5, 8'h00);

        cur_req = "R12";
        for (int k = 0; k < 6000; k++) begin
            nxt();
            if ($urandom_range(0, 5) == 0) begin
                wr_en = 1'b1;
                wr_addr = 3'($urandom_range(0, 6));
                wr_data = (wr_addr < 4 && $urandom_range(0, 1) == 1) ? 8'hFF - 8'($urandom_range(0, 3))
                                                                    : 8'($urandom);
                if (wr_addr == 3'd5 && $urandom_range(0, 3) != 0) wr_data[1:0] = 2'b11;
            end
            if ($urandom_range(0, 2) == 0) cnt_pin = 2'($urandom);
            if ($urandom_range(0, 4) == 0) gate_pin = 2'($urandom);
        end
        idle(3);
        finish_run();
    end

endmodule